// File: doc/BRIEF.md
# Mode-Programmable Pixel Bus Unpacker

This block turns a wide pixel bus word into a stream of narrow pixel values, one per pixel clock. An 8-bit mode register selects two things: the pixel depth (4 or 8 bits per pixel) and how much of the 32-bit bus carries pixel data. A separate ratio register sets how many pixel clocks one bus load lasts. The block raises a load strobe once per bus load. On the clock edge that ends the strobe cycle it captures the whole bus word. It then emits the word's pixel groups one after another, lowest-numbered group first.

The ratio is not derived from the mode, so software may program a ratio that does not match the mode. The block handles a mismatch in a fixed way. Surplus cycles emit an invalid zero pixel, and groups beyond the ratio are discarded. Mode and ratio writes are held until the next capture, so a bus load in progress always finishes with the settings it started with. Everything runs on the single pixel clock with a synchronous, active-high reset.

Top module: `pix_unpack_top`

## Requirements
- R1: Mode bits [5:0] equal to 011000, 011001, 011010 and 011011 select 4-bit pixels on a 4, 8, 16 and 32-bit bus, giving 1, 2, 4 and 8 groups per load. Group k is bus bits [4k+3:4k], and it is output zero-extended to 8 bits.
- R2: Mode bits [5:0] equal to 011100, 011101 and 011110 select 8-bit pixels on an 8, 16 and 32-bit bus, giving 1, 2 and 4 groups per load. Group k is bus bits [8k+7:8k].
- R3: Mode bits [7:6] have no effect. Any other value of bits [5:0] acts as 8-bit pixels on an 8-bit bus (1 group).
- R4: The ratio register holds a 2-bit code c, and one bus load lasts N = 2^c pixel clocks (1, 2, 4 or 8). Reset sets c = 0. Writing the mode register leaves the ratio register unchanged.
- R5: load_strobe is high for exactly one cycle in every N. bus_word is sampled only on the rising edge that ends a strobe-high cycle and is ignored on every other edge.
- R6: After a capture, the outputs show group 0 in the next cycle, then group 1, and so on, one group per clock. Consecutive loads follow each other with no idle cycle.
- R7: When N exceeds the number of groups, each surplus cycle outputs pix_out = 0 with pix_valid = 0.
- R8: When N is smaller than the number of groups, only groups 0 to N-1 are output and the higher groups are dropped.
- R9: A mode or ratio write made during a bus load does not change the rest of that load. It takes effect from the next capture onward.
- R10: While rst is high, pix_out is 0, pix_valid is 0 and load_strobe is 1. After reset the mode reads as 0 (treated per R3) and the ratio is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Write enable for the mode register |
| mode_data | input | 8 | New mode register value |
| ratio_wr | input | 1 | Write enable for the ratio register |
| ratio_code | input | 2 | New ratio code c (N = 2^c) |
| bus_word | input | 32 | Wide pixel bus word, sampled at the end of a strobe cycle |
| pix_out | output | 8 | Current pixel value, zero-extended in 4-bit modes |
| pix_valid | output | 1 | pix_out carries a real pixel group |
| load_strobe | output | 1 | High during the cycle whose closing edge captures bus_word |

## Verification
The unpacking is exercised with every listed mode, each paired with its matching ratio. This shows whether the group order and the group slicing are right for each depth and bus width. Deliberately mismatched pairs (two groups over eight clocks, eight groups over two clocks) separate surplus-cycle zero filling from upper-group dropping. Codes with bits [7:6] set, and unlisted codes, show whether the decode ignores the high bits and falls back to the single 8-bit group. A mode and ratio rewrite in the middle of a load, and a reset in the middle of a load, show whether settings switch exactly at a capture. Because bus_word is randomised on every cycle, a capture on the wrong edge shows up as a data mismatch.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    // Decoded pixel arrangement for one bus load
    typedef struct packed {
        logic       wide;   // 1: 8-bit pixels, 0: 4-bit pixels
        logic [1:0] glog;   // log2 of the number of groups per bus word
    } pix_cfg_t;

endpackage

// File: rtl/pxu_mode_decode.sv
module pxu_mode_decode
    import pxu_pkg::*;
#(
    parameter int unsigned MODE_W    = 8,
    parameter int unsigned MODE_USED = 6
) (
    input  logic [MODE_W-1:0] mode_i,
    output pix_cfg_t          cfg_o
);

    logic [MODE_USED-1:0] sel;

    // Only the low MODE_USED bits take part in the decode
    assign sel = mode_i[MODE_USED-1:0];

    always_comb begin
        case (sel)
            6'b011000: cfg_o = '{wide: 1'b0, glog: 2'd0};
            6'b011001: cfg_o = '{wide: 1'b0, glog: 2'd1};
            6'b011010: cfg_o = '{wide: 1'b0, glog: 2'd2};
            6'b011011: cfg_o = '{wide: 1'b0, glog: 2'd3};
            6'b011100: cfg_o = '{wide: 1'b1, glog: 2'd0};
            6'b011101: cfg_o = '{wide: 1'b1, glog: 2'd1};
            6'b011110: cfg_o = '{wide: 1'b1, glog: 2'd2};
            default:   cfg_o = '{wide: 1'b1, glog: 2'd0};
        endcase
    end

endmodule

// File: rtl/pxu_load_timer.sv
module pxu_load_timer #(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned RCW   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RCW-1:0]   ratio_code_i,
    output logic             load_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] nlast;   // active ratio minus one
    } tstate_t;

    tstate_t st_q, st_d;

    assign load_o = (st_q.cnt == '0);
    assign idx_o  = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load_o) begin
            st_d.nlast = IDX_W'((32'd1 << ratio_code_i) - 32'd1);
            st_d.cnt   = (st_d.nlast == '0) ? '0 : IDX_W'(1);
        end else if (st_q.cnt == st_q.nlast) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the position counter stays inside the active bus load
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.nlast);

    // R5: a ratio above one never yields back-to-back strobes
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (load_o && ratio_code_i != '0) |=> !load_o);

    // R9: the active ratio only changes at a capture
    a_r9_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> $stable(st_q.nlast));

endmodule

// File: rtl/pxu_group_sel.sv
module pxu_group_sel
    import pxu_pkg::*;
#(
    parameter int unsigned BUS_W    = 32,
    parameter int unsigned NARROW_W = 4,
    parameter int unsigned WIDE_W   = 8,
    parameter int unsigned IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BUS_W-1:0]  bus_word_i,
    input  pix_cfg_t          cfg_new_i,
    output logic [WIDE_W-1:0] pix_o,
    output logic              vld_o
);

    localparam int unsigned N_NARROW = BUS_W / NARROW_W;
    localparam int unsigned N_WIDE   = BUS_W / WIDE_W;
    localparam int unsigned WIDX_W   = $clog2(N_WIDE);
    localparam int unsigned GCNT_W   = IDX_W + 1;

    typedef struct packed {
        logic [BUS_W-1:0]  word;
        pix_cfg_t          cfg;
        logic [WIDE_W-1:0] pix;
        logic              vld;
    } sstate_t;

    sstate_t st_q, st_d;

    logic [BUS_W-1:0]    src_word;
    pix_cfg_t            src_cfg;
    logic [NARROW_W-1:0] nar_grp [N_NARROW];
    logic [WIDE_W-1:0]   wid_grp [N_WIDE];

    // A capture edge works on the incoming word and settings
    always_comb begin
        src_word = load_i ? bus_word_i : st_q.word;
        src_cfg  = load_i ? cfg_new_i  : st_q.cfg;
    end

    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
        assign nar_grp[g] = src_word[g*NARROW_W +: NARROW_W];
    end

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        assign wid_grp[g] = src_word[g*WIDE_W +: WIDE_W];
    end

    logic [GCNT_W-1:0] grp_cnt;
    logic              in_range;

    always_comb begin
        st_d      = st_q;
        st_d.word = src_word;
        st_d.cfg  = src_cfg;
        grp_cnt   = GCNT_W'(32'd1 << src_cfg.glog);
        in_range  = ({1'b0, idx_i} < grp_cnt)
                 && (!src_cfg.wide || (32'(idx_i) < N_WIDE));
        st_d.vld  = in_range;
        if (!in_range) begin
            st_d.pix = '0;
        end else if (src_cfg.wide) begin
            st_d.pix = wid_grp[idx_i[WIDX_W-1:0]];
        end else begin
            st_d.pix = WIDE_W'(nar_grp[idx_i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o = st_q.pix;
    assign vld_o = st_q.vld;

    // R7: a cycle without a pixel group shows zero
    a_r7_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> (pix_o == '0));

    // R1: narrow pixels arrive zero-extended
    a_r1_narrow_ext: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !st_q.cfg.wide) |-> (pix_o[WIDE_W-1:NARROW_W] == '0));

    // R9: the active arrangement only changes at a capture
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.cfg));

    // R5: the held word only changes at a capture
    a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.word));

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pxu_pkg::*;
#(
    parameter int unsigned BUS_W     = 32,
    parameter int unsigned NARROW_W  = 4,
    parameter int unsigned WIDE_W    = 8,
    parameter int unsigned MODE_W    = 8,
    parameter int unsigned MODE_USED = 6,
    parameter int unsigned RCW       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              ratio_wr,
    input  logic [RCW-1:0]    ratio_code,
    input  logic [BUS_W-1:0]  bus_word,
    output logic [WIDE_W-1:0] pix_out,
    output logic              pix_valid,
    output logic              load_strobe
);

    localparam int unsigned IDX_W = $clog2(BUS_W / NARROW_W);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RCW-1:0]    rcode;
    } regs_t;

    regs_t rg_q, rg_d;

    always_comb begin
        rg_d = rg_q;
        if (mode_wr) begin
            rg_d.mode = mode_data;
        end
        if (ratio_wr) begin
            rg_d.rcode = ratio_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    pix_cfg_t         cfg_prog;
    logic [IDX_W-1:0] grp_idx;

    pxu_mode_decode #(
        .MODE_W    (MODE_W),
        .MODE_USED (MODE_USED)
    ) i_decode (
        .mode_i (rg_q.mode),
        .cfg_o  (cfg_prog)
    );

    pxu_load_timer #(
        .IDX_W (IDX_W),
        .RCW   (RCW)
    ) i_timer (
        .clk          (clk),
        .rst          (rst),
        .ratio_code_i (rg_q.rcode),
        .load_o       (load_strobe),
        .idx_o        (grp_idx)
    );

    pxu_group_sel #(
        .BUS_W    (BUS_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W),
        .IDX_W    (IDX_W)
    ) i_sel (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_strobe),
        .idx_i      (grp_idx),
        .bus_word_i (bus_word),
        .cfg_new_i  (cfg_prog),
        .pix_o      (pix_out),
        .vld_o      (pix_valid)
    );

    // R4: the ratio register moves only on its own write
    a_r4_ratio_keep: assert property (@(posedge clk) disable iff (rst)
        !ratio_wr |=> $stable(rg_q.rcode));

    // R10: reset leaves a silent output and a pending strobe
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (pix_out == '0 && !pix_valid && load_strobe));

endmodule

// File: tb/test_pix_unpack_top.sv
module test_pix_unpack_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_data = '0;
    logic        ratio_wr = 1'b0;
    logic [1:0]  ratio_code = '0;
    logic [31:0] bus_word = '0;
    logic [7:0]  pix_out;
    logic        pix_valid;
    logic        load_strobe;

    always #2 clk = ~clk;

    pix_unpack_top i_pix_unpack_top (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_data   (mode_data),
        .ratio_wr    (ratio_wr),
        .ratio_code  (ratio_code),
        .bus_word    (bus_word),
        .pix_out     (pix_out),
        .pix_valid   (pix_valid),
        .load_strobe (load_strobe)
    );

    int checks = 0;
    int fails  = 0;
    int exp_pix[$];
    bit exp_vld[$];
    logic [7:0] cm = '0;   // committed mode register as the bench sees it
    logic [1:0] cr = '0;   // committed ratio code

    // R1, R2, R3: pixel width from the mode code
    function automatic int ref_bits(input logic [7:0] m);
        case (m[5:0])
            6'h18, 6'h19, 6'h1A, 6'h1B: return 4;
            default:                    return 8;
        endcase
    endfunction

    function automatic int ref_groups(input logic [7:0] m);
        case (m[5:0])
            6'h18: return 1;
            6'h19: return 2;
            6'h1A: return 4;
            6'h1B: return 8;
            6'h1C: return 1;
            6'h1D: return 2;
            6'h1E: return 4;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive a fresh word for the coming capture and queue its expected output
    task automatic push_load();
        logic [31:0] w;
        int n, b, g;
        w = $urandom;
        bus_word = w;
        n = 1 << cr;
        b = ref_bits(cm);
        g = ref_groups(cm);
        for (int k = 0; k < n; k++) begin
            if (k < g) begin
                exp_pix.push_back(int'((w >> (k * b)) & ((32'd1 << b) - 1)));
                exp_vld.push_back(1'b1);
            end else begin
                exp_pix.push_back(0);
                exp_vld.push_back(1'b0);
            end
        end
    endtask

    task automatic tick(input string tag);
        int e;
        bit ev;
        @(negedge clk);
        mode_wr  = 1'b0;
        ratio_wr = 1'b0;
        if (exp_pix.size() > 0) begin
            e  = exp_pix.pop_front();
            ev = exp_vld.pop_front();
            check(pix_out == 8'(e), tag, "pix_out", int'(pix_out), e);
            check(pix_valid == ev, tag, "pix_valid", int'(pix_valid), int'(ev));
        end
        check(load_strobe == (exp_pix.size() == 0), "R5 R6", "load_strobe",
              int'(load_strobe), int'(exp_pix.size() == 0));
        if (load_strobe) begin
            push_load();
        end else begin
            bus_word = $urandom;   // R5: must be ignored
        end
    endtask

    task automatic write_mode(input logic [7:0] m, input string tag);
        tick(tag);
        mode_wr   = 1'b1;
        mode_data = m;
        cm        = m;
    endtask

    task automatic write_ratio(input logic [1:0] c, input string tag);
        tick(tag);
        ratio_wr   = 1'b1;
        ratio_code = c;
        cr         = c;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        mode_wr  = 1'b0;
        ratio_wr = 1'b0;
        exp_pix.delete();
        exp_vld.delete();
        cm = '0;
        cr = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(pix_out == 8'h00, "R10", "pix_out in reset", int'(pix_out), 0);
            check(!pix_valid, "R10", "pix_valid in reset", int'(pix_valid), 0);
            check(load_strobe, "R10", "load_strobe in reset", int'(load_strobe), 1);
        end
        rst = 1'b0;
        push_load();
    endtask

    task automatic t_reset();
        do_reset();
        run(6, "R10 R4");   // default mode, one cycle per load
    endtask

    task automatic t_four_bit();
        for (int c = 0; c < 4; c++) begin
            write_mode(8'h18 + 8'(c), "R1 R6");
            write_ratio(2'(c), "R1 R6");
            run(24, "R1 R6");
        end
    endtask

    task automatic t_eight_bit();
        for (int c = 0; c < 3; c++) begin
            write_mode(8'h1C + 8'(c), "R2 R6");
            write_ratio(2'(c), "R2 R6");
            run(16, "R2 R6");
        end
    endtask

    task automatic t_mode_bits();
        write_ratio(2'd1, "R3");
        write_mode(8'hD9, "R3");   // high bits set, 4-bit pixels, 2 groups
        run(10, "R3");
        write_mode(8'h5E, "R3");   // high bits set, 8-bit pixels, 4 groups
        write_ratio(2'd2, "R3");
        run(12, "R3");
        write_mode(8'h1F, "R3");   // unlisted codes fall back to one 8-bit group
        run(12, "R3");
        write_mode(8'h00, "R3");
        run(12, "R3");
    endtask

    task automatic t_ratio_over();
        write_mode(8'h19, "R7");   // 2 groups
        write_ratio(2'd3, "R7");   // 8 clocks per load
        run(30, "R7");
    endtask

    task automatic t_ratio_under();
        write_mode(8'h1B, "R8");   // 8 groups
        write_ratio(2'd1, "R8");   // 2 clocks per load
        run(12, "R8");
        write_mode(8'h1E, "R8");   // 4 groups
        write_ratio(2'd0, "R8");
        run(8, "R8");
    endtask

    task automatic t_midburst();
        write_mode(8'h1B, "R9");
        write_ratio(2'd3, "R9");
        while (exp_pix.size() != 1) tick("R9");
        tick("R9");
        tick("R9");
        write_mode(8'h1C, "R4 R9");   // lands mid-load
        run(2, "R4 R9");
        write_ratio(2'd0, "R9");
        run(14, "R4 R9");
    endtask

    task automatic t_reset_mid();
        write_mode(8'h1A, "R10");
        write_ratio(2'd3, "R10");
        run(11, "R10");
        do_reset();
        run(8, "R10 R4");
    endtask

    initial begin
        t_reset();
        t_four_bit();
        t_eight_bit();
        t_mode_bits();
        t_ratio_over();
        t_ratio_under();
        t_midburst();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule